// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block keeps the status byte of a small serial non-volatile memory and rules on every write request that the command decoder passes to it. It holds a write-enable latch, a write-protect-enable flag and a three-bit protection-range selector. For each decoded write request it returns a one-cycle permit pulse. A request can target either an array byte or the status register. The serial shifter and the memory array are outside the block. The array size and the size of the small end blocks are parameters.

An array write is allowed when the write-enable latch is set and the address lies outside the range picked by the selector. A status write is checked when it is decoded, then held pending until chip select goes high, and only then does it update the register. A falling edge on the active-low write-protect pin while chip select is still low drops a pending status write and raises an abort pulse. After chip select has risen, the write-protect pin no longer affects that write.

A small state machine tracks the select frame. Its states are `ST_IDLE` (chip select high), `ST_FRAME` (chip select low, no status write pending) and `ST_PEND` (a permitted status write is waiting). Its transitions are:
- IDLE→FRAME when chip select falls.
- IDLE/FRAME→PEND when a permitted status write is decoded with chip select low.
- FRAME→IDLE when chip select rises.
- PEND→IDLE when chip select rises, which commits the write.
- PEND→FRAME when the write-protect pin falls, which aborts the write.
- PEND stays in PEND when a newer permitted status write reloads the pending value.

Top module: `nvm_status_guard`

## Requirements
- R1: The status byte reads {WPEN, 1, 1, RNG[2], RNG[1], RNG[0], WEL, RDY}, with WPEN at bit 7 and WEL at bit 1. Right after reset it reads 0x60 when `busy_i` is low.
- R2: Bit 0 (RDY) of `status_o` equals `busy_i` in every cycle.
- R3: A `wren_cmd` pulse sets WEL at the next edge only if `busy_i` is low. While `busy_i` is high the pulse is ignored. A `wrdis_cmd` pulse clears WEL at the next edge and wins over a set in the same cycle.
- R4: When `busy_i` goes from 1 to 0, WEL is 0 after the following edge.
- R5: While WEL is 0, no request gets a permit, whether it targets the array or the status register.
- R6: An array write with WEL at 1 is permitted unless its address lies in the protected range. With the default 256 bytes and 16-byte end blocks, the ranges are:
  - RNG 000: nothing protected.
  - RNG 001: 00–3F.
  - RNG 010: 40–7F.
  - RNG 011: 80–BF.
  - RNG 100: C0–FF.
  - RNG 101: 00–7F.
  - RNG 110: 00–0F.
  - RNG 111: F0–FF.
- R7: A status write with WEL at 1 is refused when WPEN is 1 and `wp_n` is low. It is permitted when WPEN is 0 or `wp_n` is high.
- R8: `wr_permit` pulses in the cycle after the request edge. A permitted status write changes WPEN (from `wr_data` bit 7) and RNG (from `wr_data` bits 4:2) only at the first edge that samples `cs_n` high.
- R9: If `wp_n` falls while `cs_n` is low and a status write is pending, `wr_abort` pulses in the cycle after the edge that sees the fall, and the status register keeps its old value.
- R10: A fall of `wp_n` after the pending status write has been committed raises no abort and does not change the committed value.
- R11: A request presented while `cs_n` is high gets no permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| wp_n | input | 1 | Write-protect pin, low protects (synchronous) |
| busy_i | input | 1 | Internal write cycle in progress |
| wren_cmd | input | 1 | Write-enable command pulse |
| wrdis_cmd | input | 1 | Write-disable command pulse |
| wr_req | input | 1 | Decoded write request strobe |
| wr_is_status | input | 1 | Request targets the status register |
| wr_addr | input | ADDR_W | Array byte address of the request |
| wr_data | input | 8 | New status byte for status writes |
| wr_permit | output | 1 | Request accepted, one-cycle pulse |
| wr_abort | output | 1 | Pending status write dropped, one-cycle pulse |
| status_o | output | 8 | Status byte for readback |

## Verification
The bench builds the block with its default parameters: a 256-byte array (`ADDR_W` = 8) and 16-byte end blocks. These values put the first and last address of every protected range, and the address just outside it, on known hexadecimal values. The vector table probes both sides of every range edge for all eight selector codes. The directed tests that follow exercise:
- the write-enable latch around busy edges;
- the lock of the status register by the write-protect pin;
- an abort while a status write is pending;
- a write-protect fall after the commit.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_PEND  = 2'd2
    } nsg_state_t;

    localparam logic [2:0] RNG_NONE = 3'b000;
    localparam logic [2:0] RNG_Q1   = 3'b001;
    localparam logic [2:0] RNG_Q2   = 3'b010;
    localparam logic [2:0] RNG_Q3   = 3'b011;
    localparam logic [2:0] RNG_Q4   = 3'b100;
    localparam logic [2:0] RNG_LOW  = 3'b101;
    localparam logic [2:0] RNG_BOT  = 3'b110;
    localparam logic [2:0] RNG_TOP  = 3'b111;

endpackage

// File: rtl/nsg_range_guard.sv
module nsg_range_guard #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 16
) (
    input  logic [2:0]        rng,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    import nsg_pkg::*;

    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam int UP_W = ADDR_W - PG_W;

    logic [1:0]      quarter;
    logic [UP_W-1:0] upper;

    assign quarter = addr[ADDR_W-1 -: 2];
    assign upper   = addr[ADDR_W-1 -: UP_W];

    always_comb begin
        unique case (rng)
            RNG_NONE: locked = 1'b0;
            RNG_Q1:   locked = (quarter == 2'd0);
            RNG_Q2:   locked = (quarter == 2'd1);
            RNG_Q3:   locked = (quarter == 2'd2);
            RNG_Q4:   locked = (quarter == 2'd3);
            RNG_LOW:  locked = ~addr[ADDR_W-1];
            RNG_BOT:  locked = (upper == '0);
            RNG_TOP:  locked = &upper;
            default:  locked = 1'b1;
        endcase
    end

endmodule

// File: rtl/nsg_wel_latch.sv
module nsg_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_cmd,
    input  logic clr_cmd,
    input  logic busy,
    output logic wel
);
    logic busy_q;
    logic done;

    assign done = busy_q & ~busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b1;
            wel    <= 1'b0;
        end else begin
            busy_q <= busy;
            if (clr_cmd || done)
                wel <= 1'b0;
            else if (set_cmd && !busy)
                wel <= 1'b1;
        end
    end

endmodule

// File: rtl/nsg_frame_fsm.sv
module nsg_frame_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       wp_n,
    input  logic       req,
    input  logic       is_status,
    input  logic       st_ok,
    input  logic       arr_ok,
    input  logic       new_wpen,
    input  logic [2:0] new_rng,
    output logic       permit,
    output logic       abort,
    output logic       commit,
    output logic       cmt_wpen,
    output logic [2:0] cmt_rng
);
    import nsg_pkg::*;

    nsg_state_t state_q, state_d;
    logic       wp_q;
    logic       wp_fall;
    logic       take;

    assign wp_fall = wp_q & ~wp_n;
    assign take    = req & is_status & st_ok & ~cs_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FRAME: begin
                if (cs_n)      state_d = ST_IDLE;
                else if (take) state_d = ST_PEND;
                else           state_d = ST_FRAME;
            end
            ST_PEND: begin
                if (cs_n)         state_d = ST_IDLE;
                else if (wp_fall) state_d = ST_FRAME;
                else              state_d = ST_PEND;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign commit = (state_q == ST_PEND) & cs_n;

    // outputs and pending value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q     <= 1'b1;
            permit   <= 1'b0;
            abort    <= 1'b0;
            cmt_wpen <= 1'b0;
            cmt_rng  <= 3'b000;
        end else begin
            wp_q   <= wp_n;
            permit <= req & ~cs_n & (is_status ? st_ok : arr_ok);
            abort  <= (state_q == ST_PEND) & ~cs_n & wp_fall;
            if (take) begin
                cmt_wpen <= new_wpen;
                cmt_rng  <= new_rng;
            end
        end
    end

endmodule

// File: rtl/nvm_status_guard.sv
module nvm_status_guard #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              busy_i,
    input  logic              wren_cmd,
    input  logic              wrdis_cmd,
    input  logic              wr_req,
    input  logic              wr_is_status,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              wr_permit,
    output logic              wr_abort,
    output logic [7:0]        status_o
);
    logic       wel;
    logic       locked;
    logic       st_ok;
    logic       arr_ok;
    logic       commit;
    logic       cmt_wpen;
    logic [2:0] cmt_rng;
    logic       wpen_q;
    logic [2:0] rng_q;
    logic       unused_bits;

    assign unused_bits = ^{wr_data[6:5], wr_data[1:0]};

    nsg_range_guard #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_range (
        .rng    (rng_q),
        .addr   (wr_addr),
        .locked (locked)
    );

    nsg_wel_latch u_wel (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_cmd (wren_cmd),
        .clr_cmd (wrdis_cmd),
        .busy    (busy_i),
        .wel     (wel)
    );

    assign arr_ok = wel & ~locked;
    assign st_ok  = wel & ~(wpen_q & ~wp_n);

    nsg_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wp_n      (wp_n),
        .req       (wr_req),
        .is_status (wr_is_status),
        .st_ok     (st_ok),
        .arr_ok    (arr_ok),
        .new_wpen  (wr_data[7]),
        .new_rng   (wr_data[4:2]),
        .permit    (wr_permit),
        .abort     (wr_abort),
        .commit    (commit),
        .cmt_wpen  (cmt_wpen),
        .cmt_rng   (cmt_rng)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wpen_q <= 1'b0;
            rng_q  <= 3'b000;
        end else if (commit) begin
            wpen_q <= cmt_wpen;
            rng_q  <= cmt_rng;
        end
    end

    assign status_o = {wpen_q, 2'b11, rng_q, wel, busy_i};

endmodule

// File: rtl/nsg_checker.sv
module nsg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wp_n,
    input logic       busy_i,
    input logic       wrdis_cmd,
    input logic       wr_req,
    input logic       wr_is_status,
    input logic       wr_permit,
    input logic       wr_abort,
    input logic [7:0] status_o
);
    // R5
    no_permit_without_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !status_o[1]) |=> !wr_permit);

    // R3
    wel_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrdis_cmd |=> !status_o[1]);

    // R4
    wel_clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_i) |=> !status_o[1]);

    // R11
    idle_no_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !wr_permit);

    // R7
    status_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_is_status && status_o[7] && !wp_n) |=> !wr_permit);

    // R9
    abort_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_abort |-> $stable(status_o[7:2]));

    // R8
    commit_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_o[7:2]) |-> ($past(cs_n) && !$past(cs_n, 2)));

    // R1
    fixed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:5] == 2'b11);
endmodule

bind nvm_status_guard nsg_checker u_nsg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .wp_n         (wp_n),
    .busy_i       (busy_i),
    .wrdis_cmd    (wrdis_cmd),
    .wr_req       (wr_req),
    .wr_is_status (wr_is_status),
    .wr_permit    (wr_permit),
    .wr_abort     (wr_abort),
    .status_o     (status_o)
);

// File: tb/test_nvm_status_guard.sv
`timescale 1ns/1ps
module test_nvm_status_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wp_n = 1'b1, busy_i = 1'b0;
    logic       wren_cmd = 1'b0, wrdis_cmd = 1'b0;
    logic       wr_req = 1'b0, wr_is_status = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic       wr_permit, wr_abort;
    logic [7:0] status_o;
    int         checks = 0, errors = 0;
    logic       got;

    always #10 clk = ~clk;

    nvm_status_guard i_nvm_status_guard (.*);

    // {rng[2:0], addr[7:0], expected permit}
    localparam logic [11:0] VEC [0:21] = '{
        {3'd0, 8'h00, 1'b1}, {3'd0, 8'hFF, 1'b1},
        {3'd1, 8'h3F, 1'b0}, {3'd1, 8'h40, 1'b1},
        {3'd2, 8'h40, 1'b0}, {3'd2, 8'h7F, 1'b0},
        {3'd2, 8'h3F, 1'b1}, {3'd2, 8'h80, 1'b1},
        {3'd3, 8'h80, 1'b0}, {3'd3, 8'hBF, 1'b0},
        {3'd3, 8'hC0, 1'b1}, {3'd4, 8'hC0, 1'b0},
        {3'd4, 8'hFF, 1'b0}, {3'd4, 8'hBF, 1'b1},
        {3'd5, 8'h00, 1'b0}, {3'd5, 8'h7F, 1'b0},
        {3'd5, 8'h80, 1'b1}, {3'd6, 8'h0F, 1'b0},
        {3'd6, 8'h10, 1'b1}, {3'd7, 8'hF0, 1'b0},
        {3'd7, 8'hEF, 1'b1}, {3'd7, 8'h00, 1'b1}
    };

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic wpen, input logic [2:0] rng);
        wren_cmd = 1'b1; tick(); wren_cmd = 1'b0;
        cs_n = 1'b0; tick();
        wr_req = 1'b1; wr_is_status = 1'b1; wr_data = {wpen, 2'b11, rng, 2'b00};
        tick(); wr_req = 1'b0; wr_is_status = 1'b0;
        cs_n = 1'b1; tick(); tick();
    endtask

    task automatic probe(input logic is_st, input logic [7:0] a, input logic [7:0] d,
                         output logic p);
        cs_n = 1'b0; tick();
        wr_req = 1'b1; wr_is_status = is_st; wr_addr = a; wr_data = d;
        tick(); p = wr_permit;
        wr_req = 1'b0; wr_is_status = 1'b0; cs_n = 1'b1; tick(); tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] cur;
        repeat (3) tick();
        rst_n = 1'b1; tick();
        chk("R1 reset status", status_o, 8'h60);
        chk("R1 reset permit", {7'd0, wr_permit}, 8'd0);

        cur = 3'd0;
        set_cfg(1'b0, 3'd0);
        chk("R8 commit rng0", status_o, 8'h62);
        for (int i = 0; i < 22; i++) begin
            if (VEC[i][11:9] != cur) begin
                cur = VEC[i][11:9];
                set_cfg(1'b0, cur);
                chk("R8 commit rng", {5'd0, status_o[4:2]}, {5'd0, cur});
            end
            probe(1'b0, VEC[i][8:1], 8'h00, got);
            chk($sformatf("R6 rng%0d addr %h", cur, VEC[i][8:1]), {7'd0, got}, {7'd0, VEC[i][0]});
        end

        // R9 abort of a pending status write
        cs_n = 1'b0; tick();
        wr_req = 1'b1; wr_is_status = 1'b1; wr_data = 8'h84;
        tick(); chk("R8 status permit", {7'd0, wr_permit}, 8'd1);
        wr_req = 1'b0; wr_is_status = 1'b0; wp_n = 1'b0;
        tick(); chk("R9 abort pulse", {7'd0, wr_abort}, 8'd1);
        wp_n = 1'b1; cs_n = 1'b1; tick(); tick();
        chk("R9 no commit", status_o, 8'h7E);

        // R7 lock with WPEN set
        set_cfg(1'b1, 3'd0);
        chk("R8 wpen commit", status_o, 8'hE2);
        wp_n = 1'b0; tick();
        probe(1'b1, 8'h00, 8'h14, got);
        chk("R7 locked status", {7'd0, got}, 8'd0);
        chk("R7 status kept", status_o, 8'hE2);
        probe(1'b0, 8'h00, 8'h00, got);
        chk("R7 array open", {7'd0, got}, 8'd1);
        wp_n = 1'b1; tick();

        // R10 wp fall after commit
        set_cfg(1'b1, 3'd5);
        chk("R7 wp high writable", status_o, 8'hF6);
        wp_n = 1'b0; tick();
        chk("R10 no abort", {7'd0, wr_abort}, 8'd0);
        chk("R10 value kept", status_o, 8'hF6);
        wp_n = 1'b1; tick();

        // R3 / R5
        wrdis_cmd = 1'b1; tick(); wrdis_cmd = 1'b0;
        chk("R3 disable clears", {7'd0, status_o[1]}, 8'd0);
        probe(1'b1, 8'h00, 8'h00, got);
        chk("R5 status denied", {7'd0, got}, 8'd0);
        probe(1'b0, 8'h80, 8'h00, got);
        chk("R5 array denied", {7'd0, got}, 8'd0);

        // R2 / R3 / R4
        busy_i = 1'b1; #1;
        chk("R2 rdy high", {7'd0, status_o[0]}, 8'd1);
        wren_cmd = 1'b1; tick(); wren_cmd = 1'b0;
        chk("R3 set ignored busy", {7'd0, status_o[1]}, 8'd0);
        busy_i = 1'b0; tick();
        chk("R2 rdy low", {7'd0, status_o[0]}, 8'd0);
        wren_cmd = 1'b1; wrdis_cmd = 1'b1; tick();
        chk("R3 disable wins", {7'd0, status_o[1]}, 8'd0);
        wrdis_cmd = 1'b0; tick(); wren_cmd = 1'b0;
        chk("R3 set idle", {7'd0, status_o[1]}, 8'd1);
        busy_i = 1'b1; tick(); busy_i = 1'b0; tick();
        chk("R4 done clears", {7'd0, status_o[1]}, 8'd0);

        // R11
        wren_cmd = 1'b1; tick(); wren_cmd = 1'b0;
        wr_req = 1'b1; wr_addr = 8'h80; tick();
        chk("R11 cs high ignored", {7'd0, wr_permit}, 8'd0);
        wr_req = 1'b0; tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule